// File: doc/BRIEF.md
# Internal I/O Space Address Decoder

This block turns a request aimed at the processor's internal address space into a physical target. The request address has its three low bits dropped. The remainder splits into a prefix at the top and an index below it. One prefix selects model-specific register space. Another selects I/O-port space. Every other prefix, including the processor-identification space, is reported as unsupported.

In register space, an index inside the implemented register range is returned as a register-mapped access at eight bytes per register. An index outside that range raises a fault. In I/O space the block carries the two-port legacy PCI configuration mechanism. A 4-byte access to port 0xCF8 reaches a config-address register held inside the block, and a write along that path loads the register. Ports 0xCFC to 0xCFF form a data window. When bit 31 of the config-address register is set, the window is redirected into PCI configuration space. When the bit is clear, the window behaves like any other port.

The decode is combinational. Its result is captured in an output register, so each accepted request gives one response one cycle later.

Top module: `ioSpaceDecoder`

## Requirements
- R1: After reset every response output is zero and the config-address register is zero, so a data-window access decodes as a plain I/O port.
- R2: A request accepted on a clock edge gives rspValid high on that same edge. When no request was accepted, rspValid and all other response outputs are zero.
- R3: The prefix is reqAddr[31:28] (register space = 1, I/O space = 2) and the index is reqAddr[27:3]. Address bits 2:0 have no effect on the result.
- R4: In register space, an index below REG_COUNT (64) gives rspRegMapped=1 and rspPaddr = index*8, with no other flag set.
- R5: In register space, an index of REG_COUNT or more gives rspFault=1 and rspPaddr=0.
- R6: In I/O space, an index with any bit above bit 15 set gives rspFault=1 and rspPaddr=0.
- R7: A 4-byte access to port 0xCF8 gives rspRegMapped=1 and rspPaddr = CFG_REG_NUM*8 (512). A 4-byte write there loads reqWrData into the config-address register.
- R8: When config-address bit 31 is set, ports 0xCFC to 0xCFF give rspUncacheable=1 and rspPaddr = 0xC1_0000_0000 OR (config-address bits 30:2 placed at bits 30:2) OR port bits 1:0.
- R9: When config-address bit 31 is clear, ports 0xCFC to 0xCFF give rspUncacheable=1 and rspPaddr = 0xC0_0000_0000 OR port.
- R10: Every other port, including 0xCF8 with a size other than 4, gives rspUncacheable=1 and rspPaddr = 0xC0_0000_0000 OR port. A write there leaves the config-address register unchanged.
- R11: Any prefix other than 1 or 2, including the identification prefix 0, gives rspUnsupported=1 and rspPaddr=0.
- R12: Every valid response raises exactly one of rspRegMapped, rspUncacheable, rspFault and rspUnsupported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present this cycle |
| reqAddr | input | ADDR_W (32) | Internal-space request address |
| reqSize | input | 4 | Access size in bytes |
| reqWrite | input | 1 | Request is a write |
| reqWrData | input | 32 | Write data, used for the config-address register |
| rspValid | output | 1 | Response present |
| rspPaddr | output | PADDR_W (40) | Decoded physical address |
| rspUncacheable | output | 1 | Target is uncacheable I/O |
| rspRegMapped | output | 1 | Target is an internal register |
| rspFault | output | 1 | General protection fault |
| rspUnsupported | output | 1 | Space not handled by this block |

## Verification
The assertions check on every cycle that the response follows a request by exactly one cycle and that idle cycles give all-zero outputs. They also check that a valid response carries exactly one class flag, and that fault and unsupported responses carry a zero address. The register-to-address scaling, the port-range fault, and the effect of config-address writes on the data window are shown only by the bench's scenarios. The same holds for the split between 0xCF8 accesses of different sizes. Each of these needs the bench to track which values the register held.

// File: rtl/ioSpaceDecoderPkg.sv
package ioSpaceDecoderPkg;

  // Decode classes produced by the control half
  typedef enum logic [1:0] {
    SPACE_REG  = 2'd0,
    SPACE_PORT = 2'd1,
    SPACE_NONE = 2'd2
  } spaceKind_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic valid;
    logic regMap;
    logic cfgReg;
    logic cfgWr;
    logic dataWin;
    logic plainPort;
    logic fault;
    logic unsup;
  } decStrobes_t;

endpackage

// File: rtl/ioSpaceDecoderCtrl.sv
module ioSpaceDecoderCtrl
  import ioSpaceDecoderPkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int PFX_W     = 4,
  parameter int PFX_REG   = 1,
  parameter int PFX_PORT  = 2,
  parameter int REG_COUNT = 64,
  localparam int IDX_W    = ADDR_W - 3 - PFX_W
) (
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [3:0]        reqSize,
  input  logic              reqWrite,
  output decStrobes_t       strobes,
  output logic [IDX_W-1:0]  index
);

  localparam int PORT_W = 16;
  localparam logic [PORT_W-1:0] CFG_ADDR_PORT = 16'h0CF8;
  localparam logic [PORT_W-3:0] DATA_WIN_BASE = 14'(16'h0CFC >> 2);

  logic [ADDR_W-4:0] shifted;
  logic [PFX_W-1:0]  prefix;
  logic [PORT_W-1:0] port;
  logic              portTooWide;
  logic              unusedLowBits;
  spaceKind_t        space;

  assign shifted       = reqAddr[ADDR_W-1:3];
  assign unusedLowBits = ^reqAddr[2:0];
  assign prefix        = shifted[ADDR_W-4 -: PFX_W];
  assign index         = shifted[IDX_W-1:0];
  assign port          = index[PORT_W-1:0];
  assign portTooWide   = |index[IDX_W-1:PORT_W];

  always_comb begin
    if (prefix == PFX_W'(PFX_REG))       space = SPACE_REG;
    else if (prefix == PFX_W'(PFX_PORT)) space = SPACE_PORT;
    else                                 space = SPACE_NONE;
  end

  always_comb begin
    strobes       = '0;
    strobes.valid = reqValid;
    if (reqValid) begin
      unique case (space)
        SPACE_REG: begin
          if (index < IDX_W'(REG_COUNT)) strobes.regMap = 1'b1;
          else                           strobes.fault  = 1'b1;
        end
        SPACE_PORT: begin
          if (portTooWide) begin
            strobes.fault = 1'b1;
          end else if (port == CFG_ADDR_PORT && reqSize == 4'd4) begin
            strobes.cfgReg = 1'b1;
            strobes.cfgWr  = reqWrite;
          end else if (port[PORT_W-1:2] == DATA_WIN_BASE) begin
            strobes.dataWin = 1'b1;
          end else begin
            strobes.plainPort = 1'b1;
          end
        end
        default: strobes.unsup = 1'b1;
      endcase
    end
  end

endmodule

// File: rtl/ioSpaceDecoderDatapath.sv
module ioSpaceDecoderDatapath
  import ioSpaceDecoderPkg::*;
#(
  parameter int IDX_W       = 25,
  parameter int PADDR_W     = 40,
  parameter int CFG_REG_NUM = 64,
  parameter logic [PADDR_W-1:0] PHYS_IO  = 40'hC0_0000_0000,
  parameter logic [PADDR_W-1:0] PHYS_CFG = 40'hC1_0000_0000
) (
  input  logic               clk,
  input  logic               rstN,
  input  decStrobes_t        strobes,
  input  logic [IDX_W-1:0]   index,
  input  logic [31:0]        wrData,
  output logic               rspValid,
  output logic [PADDR_W-1:0] rspPaddr,
  output logic               rspUncacheable,
  output logic               rspRegMapped,
  output logic               rspFault,
  output logic               rspUnsupported
);

  localparam int REG_BYTES_LOG2 = 3;

  logic [31:0]        cfgAddr;
  logic [PADDR_W-1:0] paddrNext;
  logic [15:0]        port;
  logic               unusedCfgLow;

  assign port         = index[15:0];
  assign unusedCfgLow = ^cfgAddr[1:0];

  always_ff @(posedge clk) begin
    if (!rstN)               cfgAddr <= '0;
    else if (strobes.cfgWr)  cfgAddr <= wrData;
  end

  always_comb begin
    paddrNext = '0;
    if (strobes.regMap)
      paddrNext = PADDR_W'(index) << REG_BYTES_LOG2;
    else if (strobes.cfgReg)
      paddrNext = PADDR_W'(CFG_REG_NUM) << REG_BYTES_LOG2;
    else if (strobes.dataWin && cfgAddr[31])
      paddrNext = PHYS_CFG | PADDR_W'({cfgAddr[30:2], port[1:0]});
    else if (strobes.dataWin || strobes.plainPort)
      paddrNext = PHYS_IO | PADDR_W'(port);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid       <= 1'b0;
      rspPaddr       <= '0;
      rspUncacheable <= 1'b0;
      rspRegMapped   <= 1'b0;
      rspFault       <= 1'b0;
      rspUnsupported <= 1'b0;
    end else begin
      rspValid       <= strobes.valid;
      rspPaddr       <= paddrNext;
      rspUncacheable <= strobes.dataWin | strobes.plainPort;
      rspRegMapped   <= strobes.regMap | strobes.cfgReg;
      rspFault       <= strobes.fault;
      rspUnsupported <= strobes.unsup;
    end
  end

endmodule

// File: rtl/ioSpaceDecoder.sv
module ioSpaceDecoder
  import ioSpaceDecoderPkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int PFX_W       = 4,
  parameter int PFX_REG     = 1,
  parameter int PFX_PORT    = 2,
  parameter int REG_COUNT   = 64,
  parameter int CFG_REG_NUM = 64,
  parameter int PADDR_W     = 40,
  parameter logic [PADDR_W-1:0] PHYS_IO  = 40'hC0_0000_0000,
  parameter logic [PADDR_W-1:0] PHYS_CFG = 40'hC1_0000_0000
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  input  logic [ADDR_W-1:0]  reqAddr,
  input  logic [3:0]         reqSize,
  input  logic               reqWrite,
  input  logic [31:0]        reqWrData,
  output logic               rspValid,
  output logic [PADDR_W-1:0] rspPaddr,
  output logic               rspUncacheable,
  output logic               rspRegMapped,
  output logic               rspFault,
  output logic               rspUnsupported
);

  localparam int IDX_W = ADDR_W - 3 - PFX_W;

  decStrobes_t      strobes;
  logic [IDX_W-1:0] index;

  ioSpaceDecoderCtrl #(
    .ADDR_W(ADDR_W), .PFX_W(PFX_W), .PFX_REG(PFX_REG),
    .PFX_PORT(PFX_PORT), .REG_COUNT(REG_COUNT)
  ) ctrl_i (
    .reqValid(reqValid), .reqAddr(reqAddr), .reqSize(reqSize),
    .reqWrite(reqWrite), .strobes(strobes), .index(index)
  );

  ioSpaceDecoderDatapath #(
    .IDX_W(IDX_W), .PADDR_W(PADDR_W), .CFG_REG_NUM(CFG_REG_NUM),
    .PHYS_IO(PHYS_IO), .PHYS_CFG(PHYS_CFG)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .index(index),
    .wrData(reqWrData), .rspValid(rspValid), .rspPaddr(rspPaddr),
    .rspUncacheable(rspUncacheable), .rspRegMapped(rspRegMapped),
    .rspFault(rspFault), .rspUnsupported(rspUnsupported)
  );

endmodule

// File: rtl/ioSpaceDecoderChecker.sv
module ioSpaceDecoderChecker #(
  parameter int PADDR_W = 40
) (
  input logic               clk,
  input logic               rstN,
  input logic               reqValid,
  input logic               rspValid,
  input logic [PADDR_W-1:0] rspPaddr,
  input logic               rspUncacheable,
  input logic               rspRegMapped,
  input logic               rspFault,
  input logic               rspUnsupported
);

  assert_rsp_follows_req_R2: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid);

  assert_no_rsp_without_req_R2: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !rspValid);

  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rstN)
    !rspValid |-> (rspPaddr == '0 && !rspUncacheable && !rspRegMapped
                   && !rspFault && !rspUnsupported));

  assert_one_class_R12: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> $countones({rspUncacheable, rspRegMapped, rspFault, rspUnsupported}) == 1);

  assert_fault_no_addr_R5: assert property (@(posedge clk) disable iff (!rstN)
    rspFault |-> rspPaddr == '0);

  assert_unsup_no_addr_R11: assert property (@(posedge clk) disable iff (!rstN)
    rspUnsupported |-> rspPaddr == '0);

  assert_reg_aligned_R4: assert property (@(posedge clk) disable iff (!rstN)
    rspRegMapped |-> rspPaddr[2:0] == 3'b000);

endmodule

bind ioSpaceDecoder ioSpaceDecoderChecker #(.PADDR_W(PADDR_W)) chk_i (.*);

// File: tb/ioSpaceDecoder_tb_top.sv
module ioSpaceDecoder_tb_top;

  localparam logic [39:0] IO_BASE  = 40'hC0_0000_0000;
  localparam logic [39:0] CFG_BASE = 40'hC1_0000_0000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [31:0] reqAddr = '0;
  logic [3:0]  reqSize = '0;
  logic        reqWrite = 1'b0;
  logic [31:0] reqWrData = '0;
  logic        rspValid;
  logic [39:0] rspPaddr;
  logic        rspUncacheable, rspRegMapped, rspFault, rspUnsupported;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  ioSpaceDecoder dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqSize(reqSize), .reqWrite(reqWrite), .reqWrData(reqWrData),
    .rspValid(rspValid), .rspPaddr(rspPaddr), .rspUncacheable(rspUncacheable),
    .rspRegMapped(rspRegMapped), .rspFault(rspFault), .rspUnsupported(rspUnsupported)
  );

  function automatic logic [31:0] mkAddr(input logic [3:0] pfx, input logic [24:0] idx,
                                         input logic [2:0] low);
    return {pfx, idx, low};
  endfunction

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // flags packed as {valid, uncache, regMapped, fault, unsup}
  task automatic checkRsp(input string req, input logic [39:0] expPaddr,
                          input logic [4:0] expFlags);
    check(req, {24'd0, rspPaddr}, {24'd0, expPaddr});
    check(req, {59'd0, rspValid, rspUncacheable, rspRegMapped, rspFault, rspUnsupported},
          {59'd0, expFlags});
  endtask

  // Drive at a negedge, response is sampled at the next negedge.
  task automatic issue(input logic [31:0] a, input logic [3:0] sz,
                       input logic wr, input logic [31:0] d);
    reqValid = 1'b1; reqAddr = a; reqSize = sz; reqWrite = wr; reqWrData = d;
    @(negedge clk);
    reqValid = 1'b0; reqWrite = 1'b0;
  endtask

  task automatic testReset;
    checkRsp("R1 reset outputs", 40'd0, 5'b00000);
    issue(mkAddr(4'd2, 25'h0CFD, 3'd0), 4'd1, 1'b0, 32'd0);
    checkRsp("R1 cfg reg zero after reset", IO_BASE | 40'h0CFD, 5'b11000);
    @(negedge clk);
    checkRsp("R2 idle after response", 40'd0, 5'b00000);
  endtask

  task automatic testRegSpace;
    issue(mkAddr(4'd1, 25'd5, 3'd0), 4'd8, 1'b0, 32'd0);
    checkRsp("R4 reg index 5", 40'd40, 5'b10100);
    issue(mkAddr(4'd1, 25'd63, 3'b101), 4'd8, 1'b0, 32'd0);
    checkRsp("R3 R4 reg index 63 low bits ignored", 40'd504, 5'b10100);
    issue(mkAddr(4'd1, 25'd64, 3'd0), 4'd8, 1'b0, 32'd0);
    checkRsp("R5 reg index 64 faults", 40'd0, 5'b10010);
  endtask

  task automatic testPortRange;
    issue(mkAddr(4'd2, 25'h1_0060, 3'd0), 4'd1, 1'b0, 32'd0);
    checkRsp("R6 port above 16 bits", 40'd0, 5'b10010);
    issue(mkAddr(4'd2, 25'h0060, 3'b111), 4'd1, 1'b0, 32'd0);
    checkRsp("R10 R3 plain port 0x60", IO_BASE | 40'h60, 5'b11000);
    issue(mkAddr(4'd2, 25'h0CFB, 3'd0), 4'd1, 1'b0, 32'd0);
    checkRsp("R10 port 0xCFB below window", IO_BASE | 40'hCFB, 5'b11000);
  endtask

  task automatic testConfigWindow;
    issue(mkAddr(4'd2, 25'h0CF8, 3'd0), 4'd4, 1'b1, 32'h8000_1234);
    checkRsp("R7 cfg address write", 40'd512, 5'b10100);
    issue(mkAddr(4'd2, 25'h0CFE, 3'd0), 4'd2, 1'b0, 32'd0);
    checkRsp("R8 window redirected", CFG_BASE | 40'h1236, 5'b11000);
    issue(mkAddr(4'd2, 25'h0CF8, 3'd0), 4'd2, 1'b1, 32'h0000_0000);
    checkRsp("R10 cfg port size 2 is plain", IO_BASE | 40'hCF8, 5'b11000);
    issue(mkAddr(4'd2, 25'h0CFC, 3'd0), 4'd4, 1'b0, 32'd0);
    checkRsp("R10 size-2 write left cfg alone", CFG_BASE | 40'h1234, 5'b11000);
    issue(mkAddr(4'd2, 25'h0CF8, 3'd0), 4'd4, 1'b1, 32'hFFFF_FFFF);
    issue(mkAddr(4'd2, 25'h0CFC, 3'd0), 4'd4, 1'b0, 32'd0);
    checkRsp("R8 all offset bits", CFG_BASE | 40'h7FFF_FFFC, 5'b11000);
    issue(mkAddr(4'd2, 25'h0CF8, 3'd0), 4'd4, 1'b0, 32'h0);
    issue(mkAddr(4'd2, 25'h0CFF, 3'd0), 4'd1, 1'b0, 32'd0);
    checkRsp("R7 cfg read does not write", CFG_BASE | 40'h7FFF_FFFF, 5'b11000);
    issue(mkAddr(4'd2, 25'h0CF8, 3'd0), 4'd4, 1'b1, 32'h7FFF_FFFF);
    issue(mkAddr(4'd2, 25'h0CFF, 3'd0), 4'd1, 1'b0, 32'd0);
    checkRsp("R9 enable clear falls back", IO_BASE | 40'hCFF, 5'b11000);
  endtask

  task automatic testUnsupported;
    issue(mkAddr(4'd0, 25'd3, 3'd0), 4'd4, 1'b0, 32'd0);
    checkRsp("R11 identification prefix", 40'd0, 5'b10001);
    issue(mkAddr(4'd7, 25'h0CF8, 3'd0), 4'd4, 1'b1, 32'h8000_0000);
    checkRsp("R11 unknown prefix", 40'd0, 5'b10001);
    issue(mkAddr(4'd2, 25'h0CFC, 3'd0), 4'd4, 1'b0, 32'd0);
    checkRsp("R11 unknown prefix wrote nothing", IO_BASE | 40'hCFC, 5'b11000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testRegSpace();
    testPortRange();
    testConfigWindow();
    testUnsupported();
    done = 1'b1;
  end

  initial begin
    int cycles = 0;
    while (!done && cycles < 5000) begin
      @(posedge clk);
      cycles++;
    end
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule